// File: doc/BRIEF.md
# Watchdog Timer with Keyed Disable

This block is a watchdog for a processor subsystem. A binary counter advances on every clock while the watchdog is active. When the count reaches the period picked by a 2-bit select, the block emits a one-cycle interrupt pulse. If the reset link is set, it also emits a one-cycle reset request to the chip's reset controller. Software keeps the counter from expiring by writing a restart code to a command register.

Stopping the watchdog is deliberately hard, so that a runaway program cannot do it by accident. Software must first clear the enable bit in the mode register. That alone does not stop the counter. Only a following write of the kill code to the command register halts it. Setting the enable bit again restarts counting from zero, and no code is needed for that.

Writes use a single-cycle port: a strobe, a one-bit address and a data byte. Address 0 selects the mode register. Address 1 selects the write-only command register.

A three-state controller sequences the enable and disable steps:
- ARMED: counting, enable bit set.
- UNLOCKED: still counting, enable bit cleared, waiting for the kill code.
- HALTED: counter held at zero.

The transitions are:
- arm_to_unlock: mode write with the enable bit 0 while ARMED.
- unlock_to_arm: mode write with the enable bit 1 while UNLOCKED.
- unlock_to_halt: kill code written while UNLOCKED.
- halt_to_arm: mode write with the enable bit 1 while HALTED.

Every other event leaves the state unchanged.

Top module: `wdt_keyed`

## Requirements
- R1: After reset, both outputs are 0 and the watchdog runs with period select 00 and reset link 0. The first interrupt pulse appears 2^TAP_BASE clock edges after reset is released.
- R2: Mode register bits [3:2] hold the period select code n. Code n sets the period to 2^(TAP_BASE+2n) clocks, so 00, 01, 10 and 11 give four periods that each grow by a factor of four. The counter wraps to zero on overflow and keeps running.
- R3: Each overflow produces an interrupt pulse exactly one cycle wide.
- R4: Mode register bit 1 is the reset link. The reset request pulses in the same cycle as the interrupt only when this bit is 1. When it is 0, the reset request never asserts.
- R5: Writing 0x4E to the command register (address 1) clears the counter. The next overflow then comes one full period after the write edge.
- R6: Writing 0xB1 while the enable bit is 1 clears the counter and leaves the watchdog running.
- R7: Writing the mode register with bit 7 (enable) at 0 does not stop the counter. Overflows continue.
- R8: After the enable bit has been cleared, writing 0xB1 halts the watchdog. The counter is held at zero and no pulse appears, whatever further command codes arrive.
- R9: Writing the mode register with bit 7 at 1 while halted resumes counting from zero. The first overflow comes one full period after that write.
- R10: A command write with any value other than 0x4E or 0xB1 has no effect.
- R11: With the write strobe low, the address and data inputs have no effect.
- R12: A clear code written on the edge where an overflow would happen suppresses that overflow. If the period is shortened below the current count, the overflow occurs on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 1 | 0 selects the mode register, 1 selects the command register |
| wr_data | input | 8 | Write data |
| irq_pulse | output | 1 | One-cycle overflow interrupt |
| rst_req | output | 1 | One-cycle reset request on overflow when linked |

## Verification
A write sampled on edge E takes effect on that same edge: the counter is zeroed and the state updated. Both pulses are registered, so an overflow decided at edge E is visible after E and gone after E+1. Counting from any edge that leaves the count at zero, the next pulse follows exactly one period of edges later. The bench drives each input at a falling edge and updates a requirement-level model at the next rising edge. It compares both outputs at the falling edge that follows, so every predicted pulse is checked in the single cycle where it is due. Directed windows additionally count pulses to confirm the halted state and the first-overflow timing.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;

    typedef enum logic [1:0] {
        ST_ARMED    = 2'd0,
        ST_UNLOCKED = 2'd1,
        ST_HALTED   = 2'd2
    } wdt_state_e;

    localparam logic       ADDR_MODE    = 1'b0;
    localparam logic       ADDR_CMD     = 1'b1;
    localparam logic [7:0] CODE_RESTART = 8'h4E;
    localparam logic [7:0] CODE_KILL    = 8'hB1;

    localparam int DATA_W   = 8;
    localparam int EN_BIT   = 7;
    localparam int SEL_LSB  = 2;
    localparam int SEL_W    = 2;
    localparam int LINK_BIT = 1;

endpackage

// File: rtl/wdt_keyed_regs.sv
module wdt_keyed_regs
    import wdt_keyed_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [SEL_W-1:0]  sel_q,
    output logic              link_q,
    output logic              mode_wr,
    output logic              mode_en,
    output logic              cmd_clear,
    output logic              cmd_kill
);

    logic cmd_wr;

    always_comb begin
        mode_wr   = wr_en && (wr_addr == ADDR_MODE);
        cmd_wr    = wr_en && (wr_addr == ADDR_CMD);
        mode_en   = wr_data[EN_BIT];
        cmd_kill  = cmd_wr && (wr_data == CODE_KILL);
        cmd_clear = cmd_wr && ((wr_data == CODE_RESTART) || (wr_data == CODE_KILL));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            link_q <= 1'b0;
        end else if (mode_wr) begin
            sel_q  <= wr_data[SEL_LSB +: SEL_W];
            link_q <= wr_data[LINK_BIT];
        end
    end

endmodule

// File: rtl/wdt_keyed_fsm.sv
module wdt_keyed_fsm
    import wdt_keyed_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_wr,
    input  logic       mode_en,
    input  logic       cmd_kill,
    output wdt_state_e state_q,
    output logic       run
);

    wdt_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ARMED;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: begin
                if (mode_wr && !mode_en) state_d = ST_UNLOCKED;   // arm_to_unlock
            end
            ST_UNLOCKED: begin
                if (mode_wr && mode_en)  state_d = ST_ARMED;      // unlock_to_arm
                else if (cmd_kill)       state_d = ST_HALTED;     // unlock_to_halt
            end
            ST_HALTED: begin
                if (mode_wr && mode_en)  state_d = ST_ARMED;      // halt_to_arm
            end
            default: state_d = ST_ARMED;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_ARMED, ST_UNLOCKED: run = 1'b1;
            ST_HALTED:             run = 1'b0;
            default:               run = 1'b0;
        endcase
    end

endmodule

// File: rtl/wdt_keyed_counter.sv
module wdt_keyed_counter
    import wdt_keyed_pkg::*;
#(
    parameter int TAP_BASE = 15,
    parameter int TAP_STEP = 2,
    localparam int NSEL    = 1 << SEL_W,
    localparam int CW      = TAP_BASE + TAP_STEP * (NSEL - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [SEL_W-1:0] sel,
    input  logic             link,
    output logic [CW-1:0]    cnt_q,
    output logic             irq_pulse,
    output logic             rst_req
);

    logic [NSEL-1:0] tap_hit;
    logic            ovf;

    for (genvar g = 0; g < NSEL; g++) begin : g_tap
        localparam int W = TAP_BASE + TAP_STEP * g;
        assign tap_hit[g] = (cnt_q >= CW'((64'd1 << W) - 64'd1));
    end

    assign ovf = run && !clear && tap_hit[sel];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            irq_pulse <= 1'b0;
            rst_req   <= 1'b0;
        end else begin
            irq_pulse <= ovf;
            rst_req   <= ovf && link;
            if (!run || clear || ovf) cnt_q <= '0;
            else                      cnt_q <= cnt_q + CW'(1);
        end
    end

endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
    import wdt_keyed_pkg::*;
#(
    parameter int TAP_BASE = 15,
    parameter int TAP_STEP = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_addr,
    input  logic [7:0]  wr_data,
    output logic        irq_pulse,
    output logic        rst_req
);

    localparam int CW = TAP_BASE + TAP_STEP * ((1 << SEL_W) - 1);

    logic [SEL_W-1:0] sel_q;
    logic             link_q;
    logic             mode_wr;
    logic             mode_en;
    logic             cmd_clear;
    logic             cmd_kill;
    logic             run;
    wdt_state_e       st_q;
    logic [CW-1:0]    cnt_q;

    wdt_keyed_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sel_q     (sel_q),
        .link_q    (link_q),
        .mode_wr   (mode_wr),
        .mode_en   (mode_en),
        .cmd_clear (cmd_clear),
        .cmd_kill  (cmd_kill)
    );

    wdt_keyed_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_wr  (mode_wr),
        .mode_en  (mode_en),
        .cmd_kill (cmd_kill),
        .state_q  (st_q),
        .run      (run)
    );

    wdt_keyed_counter #(
        .TAP_BASE (TAP_BASE),
        .TAP_STEP (TAP_STEP)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .clear     (cmd_clear),
        .sel       (sel_q),
        .link      (link_q),
        .cnt_q     (cnt_q),
        .irq_pulse (irq_pulse),
        .rst_req   (rst_req)
    );

endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk
    import wdt_keyed_pkg::*;
#(
    parameter int CW = 21
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq_pulse,
    input logic          rst_req,
    input logic          link_q,
    input wdt_state_e    st,
    input logic          cmd_clear,
    input logic          mode_wr,
    input logic          mode_en,
    input logic [CW-1:0] cnt
);

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    a_r4_req_needs_irq: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> irq_pulse);

    a_r4_req_needs_link: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(link_q));

    a_r5_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_clear |=> (cnt == '0));

    a_r7_enable_clear_keeps_run: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ARMED && mode_wr && !mode_en) |=> (st == ST_UNLOCKED));

    a_r8_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HALTED) |=> (!irq_pulse && cnt == '0));

    a_r9_resume_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HALTED && mode_wr && mode_en) |=> (st == ST_ARMED && cnt == '0));

endmodule

bind wdt_keyed wdt_keyed_chk #(.CW(CW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_pulse (irq_pulse),
    .rst_req   (rst_req),
    .link_q    (link_q),
    .st        (st_q),
    .cmd_clear (cmd_clear),
    .mode_wr   (mode_wr),
    .mode_en   (mode_en),
    .cnt       (cnt_q)
);

// File: tb/wdt_keyed_tb_top.sv
module wdt_keyed_tb_top;

    localparam int TB = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       irq_pulse;
    logic       rst_req;

    int checks = 0;
    int errors = 0;
    int irq_seen = 0;
    bit done = 1'b0;

    // requirement-level model
    int m_state = 0;   // 0 armed, 1 unlocked, 2 halted
    int m_cnt = 0;
    int m_sel = 0;
    bit m_link = 1'b0;
    bit m_irq = 1'b0;
    bit m_req = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    wdt_keyed #(.TAP_BASE(TB), .TAP_STEP(2)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .irq_pulse (irq_pulse),
        .rst_req   (rst_req)
    );

    function automatic int period_of(int s);
        return 1 << (TB + 2 * s);
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        bit running;
        bit is_cmd;
        bit clr;
        bit ovf;
        running = (m_state != 2);
        is_cmd  = wr_en && wr_addr;
        clr     = is_cmd && (wr_data == 8'h4E || wr_data == 8'hB1);
        ovf     = running && !clr && (m_cnt >= period_of(m_sel) - 1);
        m_irq   = ovf;
        m_req   = ovf && m_link;
        m_cnt   = (!running || clr || ovf) ? 0 : m_cnt + 1;
        if (wr_en && !wr_addr) begin
            if (wr_data[7])         m_state = 0;
            else if (m_state == 0)  m_state = 1;
            m_sel  = int'(wr_data[3:2]);
            m_link = wr_data[1];
        end else if (is_cmd && wr_data == 8'hB1 && m_state == 1) begin
            m_state = 2;
        end
    endtask

    task automatic cyc(bit w, bit a, logic [7:0] d, string tag);
        wr_en   = w;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        if (irq_pulse) irq_seen++;
        check(tag, "irq_pulse", int'(irq_pulse), int'(m_irq));
        check(tag, "rst_req", int'(rst_req), int'(m_req));
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 8'h00, tag);
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        check("R1", "irq_pulse in reset", int'(irq_pulse), 0);
        check("R1", "rst_req in reset", int'(rst_req), 0);
        rst_n = 1'b1;

        // R1: first overflow exactly one default period after release
        base = irq_seen;
        idle(period_of(0) - 1, "R1");
        check("R1", "no pulse before period", irq_seen - base, 0);
        idle(1, "R1");
        check("R1", "pulse at period", irq_seen - base, 1);
        idle(20, "R3");

        // R2: period select codes
        cyc(1'b1, 1'b0, 8'h84, "R2");
        idle(140, "R2");
        cyc(1'b1, 1'b0, 8'h88, "R2");
        idle(520, "R2");
        cyc(1'b1, 1'b0, 8'h8C, "R2");
        idle(2100, "R2");

        // R4: reset link on, then off
        cyc(1'b1, 1'b0, 8'h82, "R4");
        idle(40, "R4");
        cyc(1'b1, 1'b0, 8'h80, "R4");
        idle(40, "R4");

        // R5: restart code
        idle(9, "R5");
        cyc(1'b1, 1'b1, 8'h4E, "R5");
        idle(20, "R5");

        // R10: other command values
        cyc(1'b1, 1'b1, 8'h00, "R10");
        cyc(1'b1, 1'b1, 8'hFF, "R10");
        idle(5, "R10");
        cyc(1'b1, 1'b1, 8'h4F, "R10");
        cyc(1'b1, 1'b1, 8'hB0, "R10");
        idle(30, "R10");

        // R6: kill code while enabled
        idle(7, "R6");
        cyc(1'b1, 1'b1, 8'hB1, "R6");
        idle(40, "R6");

        // R7: enable bit cleared alone
        cyc(1'b1, 1'b0, 8'h00, "R7");
        idle(40, "R7");

        // R8: halt, then codes while halted
        cyc(1'b1, 1'b1, 8'hB1, "R8");
        base = irq_seen;
        idle(100, "R8");
        cyc(1'b1, 1'b1, 8'h4E, "R8");
        cyc(1'b1, 1'b0, 8'h02, "R8");
        idle(200, "R8");
        check("R8", "pulses while halted", irq_seen - base, 0);

        // R9: re-enable
        cyc(1'b1, 1'b0, 8'h80, "R9");
        base = irq_seen;
        idle(period_of(0) - 1, "R9");
        check("R9", "no pulse before period", irq_seen - base, 0);
        idle(1, "R9");
        check("R9", "pulse at period", irq_seen - base, 1);

        // R11: strobe low leaves the kill code unseen
        cyc(1'b1, 1'b0, 8'h00, "R11");
        cyc(1'b0, 1'b1, 8'hB1, "R11");
        base = irq_seen;
        idle(40, "R11");
        check("R11", "still counting", (irq_seen - base) > 0 ? 1 : 0, 1);
        cyc(1'b1, 1'b0, 8'h80, "R11");

        // R12: clear on the overflow edge, then period shortened
        cyc(1'b1, 1'b1, 8'h4E, "R12");
        idle(period_of(0) - 1, "R12");
        cyc(1'b1, 1'b1, 8'h4E, "R12");
        idle(10, "R12");
        cyc(1'b1, 1'b0, 8'h8C, "R12");
        idle(300, "R12");
        cyc(1'b1, 1'b0, 8'h80, "R12");
        idle(30, "R12");

        // constrained random mix
        void'($urandom(32'h5EED_0A11));
        for (int i = 0; i < 6000; i++) begin
            int r;
            logic [7:0] d;
            r = int'($urandom % 32);
            if (r == 0) begin
                d = 8'($urandom);
                if ($urandom % 4 != 0) d[7] = 1'b1;
                if ($urandom % 2 == 0) d[3] = 1'b0;
                cyc(1'b1, 1'b0, d, "RND");
            end else if (r == 1) begin
                case ($urandom % 3)
                    0: d = 8'h4E;
                    1: d = 8'hB1;
                    default: d = 8'($urandom);
                endcase
                cyc(1'b1, 1'b1, d, "RND");
            end else if (r == 2) begin
                cyc(1'b0, 1'($urandom), 8'($urandom), "RND");
            end else begin
                idle(1, "RND");
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule